// File: doc/BRIEF.md
# Mixed Page Size Translation Buffer

This block caches virtual-to-physical translations for a 32-bit virtual space and a 40-bit physical space. It holds 64 descriptors arranged as 8 sets of 8 ways. Any slot may hold a descriptor for a small 4 KB page or for a large 2 MB page. A per-entry size flag decides which address bits form the set index and the tag.

A lookup presents a virtual address, an access kind and a privilege flag. In the same cycle the block reports exactly one of three results: a hit with the physical address, a miss, or a rights fault. On a store hit to a clean page, the block raises a request so that the external table walker can mark the page dirty in memory.

The walker installs descriptors through a refill port. A refill lands on the way that already maps the same page, if there is one. Otherwise it takes an invalid way, and failing that it uses a per-set round-robin victim. A flush command drops every entry except those marked global.

Top module: `tlb_mixed`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss until a refill has been written.
- R2: A small-page entry uses set VA[14:12] and tag VA[31:15]. On a hit the physical address is {ppn[27:0], VA[11:0]}.
- R3: A large-page entry uses set VA[23:21] and tag VA[31:24]. On a hit the physical address is {ppn[18:0], VA[20:0]}, so every address inside the 2 MB page hits.
- R4: A lookup result is valid in the same cycle as the request. A refill becomes visible from the next cycle, and a lookup in the refill cycle still sees the old contents.
- R5: The access kind is encoded 0 = load, 1 = store, 2 = fetch. A fault is reported when a matching entry is hit by a store with the writable bit clear, by a fetch with the executable bit clear, or by a user access with the user bit clear. A fault gives no hit.
- R6: The cacheable output carries the entry's cacheable bit on a hit and reads 0 otherwise. The physical address also reads 0 unless there is a hit.
- R7: A store hit without a fault, on an entry whose dirty bit is clear, raises the dirty request. No other case raises it.
- R8: A refill whose page and size match a valid entry in its set overwrites that entry, so a later lookup returns the new page number.
- R9: A refill with no matching entry takes the lowest invalid way of its set. When all 8 ways are valid it takes the way named by that set's round-robin pointer. The pointer starts at 0 and advances by one on each such eviction.
- R10: A flush invalidates all entries whose global bit is clear and keeps global entries. A refill issued in the same cycle as a flush is applied after the flush and survives.
- R11: While a lookup is requested, exactly one of hit, miss and fault is high. While none is requested, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_va_i | input | 32 | Lookup virtual address |
| lkp_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lkp_user_i | input | 1 | Access made in user mode |
| lkp_hit_o | output | 1 | Translation found and rights satisfied |
| lkp_miss_o | output | 1 | No matching entry |
| lkp_fault_o | output | 1 | Matching entry, rights violated |
| lkp_pa_o | output | 40 | Physical address on hit, else 0 |
| lkp_cache_o | output | 1 | Cacheable bit of the hit entry |
| lkp_dirty_req_o | output | 1 | Store hit on a clean page |
| fill_valid_i | input | 1 | Refill write |
| fill_vpn_i | input | 20 | Refill virtual address bits 31:12 |
| fill_big_i | input | 1 | Refill is a 2 MB page |
| fill_ppn_i | input | 28 | Refill page number (low 19 bits used for 2 MB) |
| fill_cache_i | input | 1 | Refill cacheable bit |
| fill_write_i | input | 1 | Refill writable bit |
| fill_exec_i | input | 1 | Refill executable bit |
| fill_user_i | input | 1 | Refill user bit |
| fill_global_i | input | 1 | Refill global bit |
| fill_dirty_i | input | 1 | Refill dirty bit |
| flush_i | input | 1 | Invalidate non-global entries |

## Verification
A lookup and a refill can arrive in the same cycle, and so can a flush and a refill. The bench drives a lookup of a page in the very cycle its refill is written and expects a miss, then expects a hit on the next cycle. It also raises a flush together with a non-global refill and expects the refilled page to hit afterwards while the earlier non-global pages miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 40;
  localparam int SETS      = 8;
  localparam int WAYS      = 8;
  localparam int SML_OFF   = 12;
  localparam int BIG_OFF   = 21;
  localparam int SET_W     = $clog2(SETS);
  localparam int WAY_W     = $clog2(WAYS);
  localparam int IDX_W     = SET_W + WAY_W;
  localparam int SML_TAG_W = VA_W - SML_OFF - SET_W;
  localparam int BIG_TAG_W = VA_W - BIG_OFF - SET_W;
  localparam int SML_PPN_W = PA_W - SML_OFF;
  localparam int BIG_PPN_W = PA_W - BIG_OFF;
  localparam int VPN_W     = VA_W - SML_OFF;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic                 vld;
    logic                 big;
    logic [SML_TAG_W-1:0] tag;
    logic [SML_PPN_W-1:0] ppn;
    logic                 c;
    logic                 w;
    logic                 x;
    logic                 u;
    logic                 g;
    logic                 d;
  } entry_t;

  function automatic logic [SET_W-1:0] set_of(input logic [VA_W-1:0] va, input logic big);
    return big ? va[BIG_OFF +: SET_W] : va[SML_OFF +: SET_W];
  endfunction

  // large-page tags are zero-extended so one comparator width serves both
  function automatic logic [SML_TAG_W-1:0] tag_of(input logic [VA_W-1:0] va, input logic big);
    if (big) return {{(SML_TAG_W-BIG_TAG_W){1'b0}}, va[VA_W-1:BIG_OFF+SET_W]};
    return va[VA_W-1:SML_OFF+SET_W];
  endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match #(
  parameter int TAG_W = 17
) (
  input  logic             vld_i,
  input  logic             big_i,
  input  logic             want_big_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] key_i,
  output logic             match_o
);
  assign match_o = vld_i && (big_i == want_big_i) && (tag_i == key_i);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  vld_i,
  input  logic [WAYS-1:0]  same_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             evict_o
);
  always_comb begin
    way_o   = '0;
    evict_o = 1'b0;
    if (|same_i) begin
      for (int w = WAYS-1; w >= 0; w--)
        if (same_i[w]) way_o = WAY_W'(w);
    end else if (!(&vld_i)) begin
      for (int w = WAYS-1; w >= 0; w--)
        if (!vld_i[w]) way_o = WAY_W'(w);
    end else begin
      way_o   = rr_i;
      evict_o = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_rights.sv
module tlb_rights
  import tlb_pkg::*;
(
  input  acc_e kind_i,
  input  logic user_i,
  input  logic w_i,
  input  logic x_i,
  input  logic u_i,
  input  logic d_i,
  output logic fault_o,
  output logic dreq_o
);
  logic bad;
  always_comb begin
    bad = (user_i && !u_i)
       || (kind_i == ACC_STORE && !w_i)
       || (kind_i == ACC_FETCH && !x_i);
    fault_o = bad;
    dreq_o  = (kind_i == ACC_STORE) && !d_i && !bad;
  end
endmodule

// File: rtl/tlb_mixed.sv
module tlb_mixed
  import tlb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lkp_valid_i,
  input  logic [VA_W-1:0]      lkp_va_i,
  input  logic [1:0]           lkp_kind_i,
  input  logic                 lkp_user_i,
  output logic                 lkp_hit_o,
  output logic                 lkp_miss_o,
  output logic                 lkp_fault_o,
  output logic [PA_W-1:0]      lkp_pa_o,
  output logic                 lkp_cache_o,
  output logic                 lkp_dirty_req_o,
  input  logic                 fill_valid_i,
  input  logic [VPN_W-1:0]     fill_vpn_i,
  input  logic                 fill_big_i,
  input  logic [SML_PPN_W-1:0] fill_ppn_i,
  input  logic                 fill_cache_i,
  input  logic                 fill_write_i,
  input  logic                 fill_exec_i,
  input  logic                 fill_user_i,
  input  logic                 fill_global_i,
  input  logic                 fill_dirty_i,
  input  logic                 flush_i
);
  localparam int N_ENT = SETS * WAYS;

  entry_t           tlb_q [N_ENT];
  logic [WAY_W-1:0] rr_q  [SETS];

  // lookup keys for both page sizes
  logic [SET_W-1:0]     s_set, b_set;
  logic [SML_TAG_W-1:0] s_tag, b_tag;
  assign s_set = set_of(lkp_va_i, 1'b0);
  assign b_set = set_of(lkp_va_i, 1'b1);
  assign s_tag = tag_of(lkp_va_i, 1'b0);
  assign b_tag = tag_of(lkp_va_i, 1'b1);

  // refill keys
  logic [VA_W-1:0]      fill_va;
  logic [SET_W-1:0]     f_set;
  logic [SML_TAG_W-1:0] f_tag;
  assign fill_va = {fill_vpn_i, {SML_OFF{1'b0}}};
  assign f_set   = set_of(fill_va, fill_big_i);
  assign f_tag   = tag_of(fill_va, fill_big_i);

  logic [WAYS-1:0] s_hit, b_hit, f_vld, f_match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WID = WAY_W'(w);

    tlb_entry_match #(.TAG_W(SML_TAG_W)) u_sml (
      .vld_i      (tlb_q[{s_set, WID}].vld),
      .big_i      (tlb_q[{s_set, WID}].big),
      .want_big_i (1'b0),
      .tag_i      (tlb_q[{s_set, WID}].tag),
      .key_i      (s_tag),
      .match_o    (s_hit[w])
    );

    tlb_entry_match #(.TAG_W(SML_TAG_W)) u_big (
      .vld_i      (tlb_q[{b_set, WID}].vld),
      .big_i      (tlb_q[{b_set, WID}].big),
      .want_big_i (1'b1),
      .tag_i      (tlb_q[{b_set, WID}].tag),
      .key_i      (b_tag),
      .match_o    (b_hit[w])
    );

    // validity as seen after a same-cycle flush
    assign f_vld[w] = tlb_q[{f_set, WID}].vld && !(flush_i && !tlb_q[{f_set, WID}].g);

    tlb_entry_match #(.TAG_W(SML_TAG_W)) u_fill (
      .vld_i      (f_vld[w]),
      .big_i      (tlb_q[{f_set, WID}].big),
      .want_big_i (fill_big_i),
      .tag_i      (tlb_q[{f_set, WID}].tag),
      .key_i      (f_tag),
      .match_o    (f_match[w])
    );
  end

  // small pages win over large, lower way wins within a size
  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (b_hit[w]) begin
        sel_hit = 1'b1;
        sel_idx = {b_set, WAY_W'(w)};
      end
    for (int w = WAYS-1; w >= 0; w--)
      if (s_hit[w]) begin
        sel_hit = 1'b1;
        sel_idx = {s_set, WAY_W'(w)};
      end
  end

  entry_t sel_ent;
  assign sel_ent = tlb_q[sel_idx];

  logic rgt_fault, rgt_dreq;
  tlb_rights u_rights (
    .kind_i  (acc_e'(lkp_kind_i)),
    .user_i  (lkp_user_i),
    .w_i     (sel_ent.w),
    .x_i     (sel_ent.x),
    .u_i     (sel_ent.u),
    .d_i     (sel_ent.d),
    .fault_o (rgt_fault),
    .dreq_o  (rgt_dreq)
  );

  logic [PA_W-1:0] raw_pa;
  assign raw_pa = sel_ent.big ? {sel_ent.ppn[BIG_PPN_W-1:0], lkp_va_i[BIG_OFF-1:0]}
                              : {sel_ent.ppn, lkp_va_i[SML_OFF-1:0]};

  logic hit;
  assign hit             = lkp_valid_i && sel_hit && !rgt_fault;
  assign lkp_hit_o       = hit;
  assign lkp_fault_o     = lkp_valid_i && sel_hit && rgt_fault;
  assign lkp_miss_o      = lkp_valid_i && !sel_hit;
  assign lkp_pa_o        = hit ? raw_pa : '0;
  assign lkp_cache_o     = hit && sel_ent.c;
  assign lkp_dirty_req_o = hit && rgt_dreq;

  // victim selection
  logic [WAY_W-1:0] vic_way;
  logic             vic_evict;
  tlb_victim #(.WAYS(WAYS)) u_victim (
    .vld_i   (f_vld),
    .same_i  (f_match),
    .rr_i    (rr_q[f_set]),
    .way_o   (vic_way),
    .evict_o (vic_evict)
  );

  entry_t new_ent;
  always_comb begin
    new_ent     = '0;
    new_ent.vld = 1'b1;
    new_ent.big = fill_big_i;
    new_ent.tag = f_tag;
    new_ent.ppn = fill_ppn_i;
    new_ent.c   = fill_cache_i;
    new_ent.w   = fill_write_i;
    new_ent.x   = fill_exec_i;
    new_ent.u   = fill_user_i;
    new_ent.g   = fill_global_i;
    new_ent.d   = fill_dirty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) tlb_q[i] <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      if (flush_i) begin
        for (int i = 0; i < N_ENT; i++)
          if (!tlb_q[i].g) tlb_q[i].vld <= 1'b0;
      end
      if (fill_valid_i) begin
        tlb_q[{f_set, vic_way}] <= new_ent;
        if (vic_evict) rr_q[f_set] <= rr_q[f_set] + WAY_W'(1);
      end
    end
  end
endmodule

// File: rtl/tlb_mixed_chk.sv
module tlb_mixed_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lkp_valid_i,
  input logic [31:0] lkp_va_i,
  input logic [1:0]  lkp_kind_i,
  input logic        lkp_hit_o,
  input logic        lkp_miss_o,
  input logic        lkp_fault_o,
  input logic [39:0] lkp_pa_o,
  input logic        lkp_dirty_req_o,
  input logic        fill_valid_i,
  input logic        fill_global_i,
  input logic        flush_i
);
  logic any_fill_q, glob_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      any_fill_q <= 1'b0;
      glob_q     <= 1'b0;
    end else if (fill_valid_i) begin
      any_fill_q <= 1'b1;
      if (fill_global_i) glob_q <= 1'b1;
    end
  end

  a_r11_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |-> $onehot({lkp_hit_o, lkp_miss_o, lkp_fault_o}));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> !(lkp_hit_o || lkp_miss_o || lkp_fault_o));

  a_r1_empty_misses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !any_fill_q) |-> lkp_miss_o);

  a_r7_dirty_on_store_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_dirty_req_o |-> (lkp_hit_o && lkp_kind_i == 2'd1));

  a_r2_offset_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> (lkp_pa_o[11:0] == lkp_va_i[11:0]));

  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flush_i && !fill_valid_i) && !glob_q && lkp_valid_i) |-> lkp_miss_o);
endmodule

bind tlb_mixed tlb_mixed_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .lkp_valid_i     (lkp_valid_i),
  .lkp_va_i        (lkp_va_i),
  .lkp_kind_i      (lkp_kind_i),
  .lkp_hit_o       (lkp_hit_o),
  .lkp_miss_o      (lkp_miss_o),
  .lkp_fault_o     (lkp_fault_o),
  .lkp_pa_o        (lkp_pa_o),
  .lkp_dirty_req_o (lkp_dirty_req_o),
  .fill_valid_i    (fill_valid_i),
  .fill_global_i   (fill_global_i),
  .flush_i         (flush_i)
);

// File: tb/tlb_mixed_tb.sv
module tlb_mixed_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_va = '0;
  logic [1:0]  lkp_kind = '0;
  logic        lkp_user = 1'b0;
  logic        hit, miss, fault, cache, dreq;
  logic [39:0] pa;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic        fill_big = 1'b0;
  logic [27:0] fill_ppn = '0;
  logic        f_c = 1'b0, f_w = 1'b0, f_x = 1'b0, f_u = 1'b0, f_g = 1'b0, f_d = 1'b0;
  logic        flush = 1'b0;

  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_FE = 2'd2;

  always #4 clk = ~clk;

  tlb_mixed u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_va_i(lkp_va), .lkp_kind_i(lkp_kind), .lkp_user_i(lkp_user),
    .lkp_hit_o(hit), .lkp_miss_o(miss), .lkp_fault_o(fault), .lkp_pa_o(pa),
    .lkp_cache_o(cache), .lkp_dirty_req_o(dreq),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_big_i(fill_big), .fill_ppn_i(fill_ppn),
    .fill_cache_i(f_c), .fill_write_i(f_w), .fill_exec_i(f_x), .fill_user_i(f_u),
    .fill_global_i(f_g), .fill_dirty_i(f_d), .flush_i(flush)
  );

  logic [44:0] exp_q[$];
  string       tag_q[$];
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  function automatic logic [44:0] e_hit(input logic [39:0] p, input logic c, input logic d);
    return {1'b1, 1'b0, 1'b0, c, d, p};
  endfunction
  function automatic logic [44:0] e_miss();
    return {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 40'h0};
  endfunction
  function automatic logic [44:0] e_fault();
    return {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 40'h0};
  endfunction
  function automatic logic [39:0] sml_pa(input logic [27:0] p, input logic [31:0] va);
    return {p, va[11:0]};
  endfunction
  function automatic logic [39:0] big_pa(input logic [27:0] p, input logic [31:0] va);
    return {p[18:0], va[20:0]};
  endfunction
  function automatic logic [19:0] rep_vpn(input int i);
    return 20'(((i + 256) << 3) | 3);
  endfunction

  // monitor: compares each lookup result with the scoreboard head
  initial forever begin
    @(negedge clk);
    #1;
    if (lkp_valid) begin
      logic [44:0] act, e;
      string t;
      act = {hit, miss, fault, cache, dreq, pa};
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL unexpected lookup act=%h exp=none", act);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          n_err++;
          $display("FAIL %s act=%h exp=%h", t, act, e);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    lkp_valid  = 1'b0;
    fill_valid = 1'b0;
    flush      = 1'b0;
  endtask

  task automatic lk(input logic [31:0] va, input logic [1:0] k, input logic usr,
                    input logic [44:0] e, input string t);
    lkp_valid = 1'b1;
    lkp_va    = va;
    lkp_kind  = k;
    lkp_user  = usr;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic fl(input logic [19:0] vpn, input logic big, input logic [27:0] ppn,
                    input logic c, input logic w, input logic x, input logic u,
                    input logic g, input logic d);
    fill_valid = 1'b1;
    fill_vpn   = vpn;
    fill_big   = big;
    fill_ppn   = ppn;
    f_c = c; f_w = w; f_x = x; f_u = u; f_g = g; f_d = d;
  endtask

  task automatic chk_idle(input string t);
    step();
    #2;
    n_chk++;
    if ({hit, miss, fault, dreq} !== 4'b0) begin
      n_err++;
      $display("FAIL %s act=%b exp=0000", t, {hit, miss, fault, dreq});
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=running exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    chk_idle("R11 idle after reset");
    step(); lk(32'h1234_5678, K_LD, 1'b1, e_miss(), "R1 empty after reset");

    // small page
    step(); fl(20'h12345, 1'b0, 28'h0ABCDEF, 1, 1, 1, 1, 0, 1);
    step(); lk(32'h1234_5678, K_LD, 1'b1, e_hit(sml_pa(28'h0ABCDEF, 32'h1234_5678), 1, 0), "R2 small hit");
    step(); lk(32'h1234_5FFC, K_ST, 1'b1, e_hit(sml_pa(28'h0ABCDEF, 32'h1234_5FFC), 1, 0), "R7 store to dirty page");
    step(); lk(32'h1234_6000, K_LD, 1'b1, e_miss(), "R2 neighbour page misses");

    // large page, global, not cacheable
    step(); fl(20'h40200, 1'b1, 28'h005A5A5, 0, 1, 1, 1, 1, 1);
    step(); lk(32'h403F_FFFF, K_FE, 1'b1, e_hit(big_pa(28'h005A5A5, 32'h403F_FFFF), 0, 0), "R3 large hit top");
    step(); lk(32'h4020_0123, K_LD, 1'b0, e_hit(big_pa(28'h005A5A5, 32'h4020_0123), 0, 0), "R6 large hit uncached");
    step(); lk(32'h4040_0000, K_LD, 1'b0, e_miss(), "R3 next large page misses");

    // restricted small page in the same set as the large one
    step(); fl(20'h00001, 1'b0, 28'h1111111, 1, 0, 0, 0, 0, 1);
    step(); lk(32'h0000_1ABC, K_ST, 1'b0, e_fault(), "R5 store to read-only");
    step(); lk(32'h0000_1ABC, K_FE, 1'b0, e_fault(), "R5 fetch from no-exec");
    step(); lk(32'h0000_1ABC, K_LD, 1'b1, e_fault(), "R5 user on supervisor page");
    step(); lk(32'h0000_1ABC, K_LD, 1'b0, e_hit(sml_pa(28'h1111111, 32'h0000_1ABC), 1, 0), "R5 supervisor load ok");

    // clean writable page
    step(); fl(20'h00002, 1'b0, 28'h2222222, 1, 1, 0, 1, 0, 0);
    step(); lk(32'h0000_2004, K_ST, 1'b1, e_hit(sml_pa(28'h2222222, 32'h0000_2004), 1, 1), "R7 store to clean page");
    step(); lk(32'h0000_2004, K_LD, 1'b1, e_hit(sml_pa(28'h2222222, 32'h0000_2004), 1, 0), "R7 load no request");
    step(); lk(32'h0000_2004, K_FE, 1'b1, e_fault(), "R7 faulting fetch no request");

    // lookup and refill in the same cycle
    step(); fl(20'h00006, 1'b0, 28'h6666666, 1, 1, 1, 1, 0, 1);
            lk(32'h0000_6010, K_LD, 1'b0, e_miss(), "R4 lookup during refill");
    step(); lk(32'h0000_6010, K_LD, 1'b0, e_hit(sml_pa(28'h6666666, 32'h0000_6010), 1, 0), "R4 visible next cycle");

    // overwrite an existing mapping
    step(); fl(20'h12345, 1'b0, 28'h0FEDCBA, 1, 1, 1, 1, 0, 1);
    step(); lk(32'h1234_5001, K_LD, 1'b0, e_hit(sml_pa(28'h0FEDCBA, 32'h1234_5001), 1, 0), "R8 refill replaces");

    // replacement in set 3
    for (int i = 0; i < 9; i++) begin
      step(); fl(rep_vpn(i), 1'b0, 28'h3000000 + 28'(i), 1, 1, 1, 1, 0, 1);
    end
    step(); lk({rep_vpn(0), 12'h0}, K_LD, 1'b0, e_miss(), "R9 first eviction takes way 0");
    step(); lk({rep_vpn(1), 12'h0}, K_LD, 1'b0, e_hit({28'h3000001, 12'h0}, 1, 0), "R9 way 1 kept");
    step(); lk({rep_vpn(8), 12'h0}, K_LD, 1'b0, e_hit({28'h3000008, 12'h0}, 1, 0), "R9 newest present");
    step(); fl(rep_vpn(9), 1'b0, 28'h3000009, 1, 1, 1, 1, 0, 1);
    step(); lk({rep_vpn(1), 12'h0}, K_LD, 1'b0, e_miss(), "R9 pointer advanced to way 1");
    step(); lk({rep_vpn(2), 12'h0}, K_LD, 1'b0, e_hit({28'h3000002, 12'h0}, 1, 0), "R9 way 2 kept");
    step(); lk({rep_vpn(9), 12'h0}, K_LD, 1'b0, e_hit({28'h3000009, 12'h0}, 1, 0), "R9 new entry");

    // flush keeps the global large page
    step(); flush = 1'b1;
    step(); lk(32'h1234_5001, K_LD, 1'b0, e_miss(), "R10 non-global dropped");
    step(); lk(32'h0000_1ABC, K_LD, 1'b0, e_miss(), "R10 restricted page dropped");
    step(); lk(32'h4020_0123, K_LD, 1'b0, e_hit(big_pa(28'h005A5A5, 32'h4020_0123), 0, 0), "R10 global kept");

    // flush and refill in the same cycle
    step(); fl(20'h00002, 1'b0, 28'h2222222, 1, 1, 1, 1, 0, 1);
    step(); flush = 1'b1; fl(20'h00007, 1'b0, 28'h7777777, 1, 1, 1, 1, 0, 1);
    step(); lk(32'h0000_7FFF, K_LD, 1'b0, e_hit(sml_pa(28'h7777777, 32'h0000_7FFF), 1, 0), "R10 refill survives flush");
    step(); lk(32'h0000_2004, K_LD, 1'b0, e_miss(), "R10 earlier refill flushed");

    chk_idle("R11 idle at end");
    step(); step();
    if (exp_q.size() != 0) begin
      n_chk++;
      n_err++;
      $display("FAIL R11 pending results act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule